// File: doc/BRIEF.md
# Privilege Mode and Exception Controller

This block keeps the privilege level of an execution core and decides what happens when something goes wrong or when software asks for service. The core runs in one of three levels: user, supervisor and fault. At each instruction boundary the block looks at the synchronous causes of the instruction (a supervisor call, an undecodable instruction, or a hit on the hardware breakpoint or watchpoint comparators, which are inside the block). It also looks at a latched hardware-management event from outside the core. It then picks the level to enter, saves the interrupted PC and level for that level, and sends a one-cycle redirect strobe to the handler vector of the cause. A return request brings the core back one level to the saved PC.

The control is a four-state machine. The states are USER, SUPER, FAULT and HALT, and every output is registered. The transitions are as follows. USER→SUPER on any synchronous cause or on a pending hardware-management event. SUPER→FAULT on any synchronous cause (a debug hit there becomes the supervisor-debug cause). SUPER→USER on a return. FAULT→SUPER on a return. FAULT→HALT on any synchronous cause. HALT is left only through reset. Cause codes are 0 supervisor call, 1 debug, 2 supervisor-debug, 3 unknown instruction and 4 hardware management. The handler vector is `VEC_BASE + (code << VEC_SHIFT)`, with defaults 0x000100 and 4, so the vectors are 0x100, 0x110, 0x120, 0x130 and 0x140.

Top module: `priv_exc_ctrl`

## Requirements
- R1: After reset the mode output is 0 (user), halted is 0, no redirect is signalled, the hardware-management event is not pending, and both saved PCs and saved modes are 0.
- R2: A synchronous cause presented with `insn_valid` in user mode makes the next cycle show mode 1 (supervisor), a one-cycle redirect to the cause's vector, the cause code on `cause_o`, `sv_epc_o` equal to the instruction PC and `sv_emode_o` equal to 0.
- R3: When several synchronous causes arrive together, debug (code 1) wins over unknown instruction (code 3), and unknown instruction wins over supervisor call (code 0).
- R4: A debug hit occurs only with `insn_valid`, and only when the breakpoint is enabled and `insn_pc` equals its address, or when the watchpoint is enabled, `dacc_valid` is 1 and `dacc_addr` equals its address. A disabled comparator never hits.
- R5: A supervisor call or unknown instruction in supervisor mode enters fault mode (mode 2) with its own code and vector, saving `flt_epc_o` equal to the PC and `flt_emode_o` equal to 1.
- R6: A debug hit in supervisor mode enters fault mode with code 2. A return from fault mode restores mode 1 and redirects to `flt_epc_o`.
- R7: A return in supervisor mode restores mode 0 and redirects to `sv_epc_o`. A return in user mode changes nothing and gives no redirect.
- R8: A `hwm_evt` pulse is held pending. It is taken with code 4 at the first `insn_valid` cycle in user mode, one cycle or more after the pulse, and the PC of that cycle is saved. It is never taken in supervisor or fault mode. A synchronous cause in the same cycle is taken first.
- R9: A synchronous cause in fault mode halts the core: `halted_o` is 1, the mode stays 2, no redirect is given, and later returns or causes have no effect until reset.
- R10: When a synchronous cause and a return arrive in the same cycle, the exception is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | An instruction boundary is presented this cycle |
| insn_pc | input | AW | Fetch address of the presented instruction |
| svc_req | input | 1 | Presented instruction is a supervisor call |
| undef_req | input | 1 | Presented instruction could not be decoded |
| dacc_valid | input | 1 | Presented instruction makes a data access |
| dacc_addr | input | AW | Data access address |
| bkpt_en | input | 1 | Breakpoint comparator enable |
| bkpt_addr | input | AW | Breakpoint address |
| wpt_en | input | 1 | Watchpoint comparator enable |
| wpt_addr | input | AW | Watchpoint address |
| hwm_evt | input | 1 | Asynchronous hardware-management event pulse |
| ret_req | input | 1 | Return-from-exception request |
| mode_o | output | 2 | Current mode: 0 user, 1 supervisor, 2 fault |
| halted_o | output | 1 | Core halted until reset |
| redir_valid_o | output | 1 | One-cycle redirect strobe |
| redir_pc_o | output | AW | Redirect target PC |
| cause_o | output | 3 | Code of the last exception taken |
| sv_epc_o | output | AW | PC saved on supervisor entry |
| sv_emode_o | output | 2 | Mode saved on supervisor entry |
| flt_epc_o | output | AW | PC saved on fault entry |
| flt_emode_o | output | 2 | Mode saved on fault entry |

## Verification
A wrong state register shows up in the cycle after the edge that caused it. The mode output is wrong at once, and the redirect target of the next return comes from the wrong saved PC. A lost or stuck pending event shows up as a missing or extra code-4 redirect at the first user-mode boundary. A wrong priority shows up as a wrong `cause_o` and vector in the same cycle as the redirect strobe. Because the halt state ignores everything, a wrong exit from it is seen on the very next return.

// File: rtl/priv_pkg.sv
`timescale 1ns/1ps
package priv_pkg;
    typedef enum logic [1:0] {
        MODE_USER  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_FAULT = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        CAUSE_SVC   = 3'd0,
        CAUSE_DBG   = 3'd1,
        CAUSE_SDBG  = 3'd2,
        CAUSE_UNDEF = 3'd3,
        CAUSE_HWM   = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_USER,
        ST_SUPER,
        ST_FAULT,
        ST_HALT
    } state_e;
endpackage

// File: rtl/priv_dbg_match.sv
`timescale 1ns/1ps
module priv_dbg_match #(
    parameter int AW = 24
) (
    input  logic          insn_valid,
    input  logic [AW-1:0] insn_pc,
    input  logic          dacc_valid,
    input  logic [AW-1:0] dacc_addr,
    input  logic          bkpt_en,
    input  logic [AW-1:0] bkpt_addr,
    input  logic          wpt_en,
    input  logic [AW-1:0] wpt_addr,
    output logic          hit_o
);
    logic fetch_hit;
    logic data_hit;

    // R4: each comparator counts only when enabled and when its access exists
    assign fetch_hit = bkpt_en && (insn_pc == bkpt_addr);
    assign data_hit  = wpt_en && dacc_valid && (dacc_addr == wpt_addr);
    assign hit_o     = insn_valid && (fetch_hit || data_hit);
endmodule

// File: rtl/priv_async_pend.sv
`timescale 1ns/1ps
module priv_async_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;

    // A new event wins over a clear that happens in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !clr_i) || evt_i;
    end

    assign pend_o = pend_q;

    a_r8_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pend_o);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !pend_o);
endmodule

// File: rtl/priv_mode_fsm.sv
`timescale 1ns/1ps
module priv_mode_fsm
    import priv_pkg::*;
#(
    parameter int              AW        = 24,
    parameter logic [AW-1:0]   VEC_BASE  = 'h100,
    parameter int              VEC_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_valid,
    input  logic [AW-1:0] insn_pc,
    input  logic          svc_req,
    input  logic          undef_req,
    input  logic          dbg_hit,
    input  logic          ret_req,
    input  logic          pend_i,
    output logic          hwm_take_o,
    output mode_e         mode_o,
    output logic          halted_o,
    output logic          redir_valid_o,
    output logic [AW-1:0] redir_pc_o,
    output cause_e        cause_o,
    output logic [AW-1:0] sv_epc_o,
    output mode_e         sv_emode_o,
    output logic [AW-1:0] flt_epc_o,
    output mode_e         flt_emode_o
);
    state_e        st_q, st_d;
    logic          sync_any;
    cause_e        sync_code;
    logic          take;
    logic          ret_go;
    cause_e        code;

    logic          redir_valid_q;
    logic [AW-1:0] redir_pc_q;
    cause_e        cause_q;
    logic [AW-1:0] sv_epc_q, flt_epc_q;
    mode_e         sv_emode_q, flt_emode_q;

    function automatic logic [AW-1:0] vec_of(input cause_e c);
        return VEC_BASE + (AW'(c) << VEC_SHIFT);
    endfunction

    // R3: debug before unknown instruction before supervisor call
    assign sync_any  = insn_valid && (dbg_hit || undef_req || svc_req);
    assign sync_code = dbg_hit ? CAUSE_DBG : (undef_req ? CAUSE_UNDEF : CAUSE_SVC);

    always_comb begin
        st_d   = st_q;
        take   = 1'b0;
        ret_go = 1'b0;
        code   = CAUSE_SVC;
        unique case (st_q)
            ST_USER: begin
                if (sync_any) begin
                    st_d = ST_SUPER;
                    take = 1'b1;
                    code = sync_code;
                end else if (insn_valid && pend_i) begin
                    st_d = ST_SUPER;
                    take = 1'b1;
                    code = CAUSE_HWM;
                end
            end
            ST_SUPER: begin
                if (sync_any) begin
                    st_d = ST_FAULT;
                    take = 1'b1;
                    code = dbg_hit ? CAUSE_SDBG : sync_code;
                end else if (ret_req) begin
                    st_d   = ST_USER;
                    ret_go = 1'b1;
                end
            end
            ST_FAULT: begin
                if (sync_any) begin
                    st_d = ST_HALT;
                end else if (ret_req) begin
                    st_d   = ST_SUPER;
                    ret_go = 1'b1;
                end
            end
            ST_HALT: st_d = ST_HALT;
            default: st_d = ST_HALT;
        endcase
    end

    assign hwm_take_o = take && (code == CAUSE_HWM);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_USER;
        else        st_q <= st_d;
    end

    // Registered outputs and saved state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_valid_q <= 1'b0;
            redir_pc_q    <= '0;
            cause_q       <= CAUSE_SVC;
            sv_epc_q      <= '0;
            sv_emode_q    <= MODE_USER;
            flt_epc_q     <= '0;
            flt_emode_q   <= MODE_USER;
        end else begin
            redir_valid_q <= take || ret_go;
            if (take) begin
                redir_pc_q <= vec_of(code);
                cause_q    <= code;
            end else if (ret_go) begin
                redir_pc_q <= (st_q == ST_SUPER) ? sv_epc_q : flt_epc_q;
            end
            if (take && st_q == ST_USER) begin
                sv_epc_q   <= insn_pc;
                sv_emode_q <= MODE_USER;
            end
            if (take && st_q == ST_SUPER) begin
                flt_epc_q   <= insn_pc;
                flt_emode_q <= MODE_SUPER;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_USER:  mode_o = MODE_USER;
            ST_SUPER: mode_o = MODE_SUPER;
            default:  mode_o = MODE_FAULT;
        endcase
    end

    assign halted_o      = (st_q == ST_HALT);
    assign redir_valid_o = redir_valid_q;
    assign redir_pc_o    = redir_pc_q;
    assign cause_o       = cause_q;
    assign sv_epc_o      = sv_epc_q;
    assign sv_emode_o    = sv_emode_q;
    assign flt_epc_o     = flt_epc_q;
    assign flt_emode_o   = flt_emode_q;

    a_r2_user_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_USER && sync_any) |=>
            (mode_o == MODE_SUPER && redir_valid_o && sv_epc_o == $past(insn_pc)));
    a_r6_super_debug: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SUPER && insn_valid && dbg_hit) |=>
            (mode_o == MODE_FAULT && cause_o == CAUSE_SDBG));
    a_r7_return_user: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SUPER && ret_req && !sync_any) |=>
            (mode_o == MODE_USER && redir_valid_o && redir_pc_o == $past(sv_epc_o)));
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && !redir_valid_o && mode_o == MODE_FAULT));
    a_r8_async_user_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_USER) |-> !hwm_take_o);
endmodule

// File: rtl/priv_exc_ctrl.sv
`timescale 1ns/1ps
module priv_exc_ctrl #(
    parameter int            AW        = 24,
    parameter logic [AW-1:0] VEC_BASE  = 'h100,
    parameter int            VEC_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_valid,
    input  logic [AW-1:0] insn_pc,
    input  logic          svc_req,
    input  logic          undef_req,
    input  logic          dacc_valid,
    input  logic [AW-1:0] dacc_addr,
    input  logic          bkpt_en,
    input  logic [AW-1:0] bkpt_addr,
    input  logic          wpt_en,
    input  logic [AW-1:0] wpt_addr,
    input  logic          hwm_evt,
    input  logic          ret_req,
    output logic [1:0]    mode_o,
    output logic          halted_o,
    output logic          redir_valid_o,
    output logic [AW-1:0] redir_pc_o,
    output logic [2:0]    cause_o,
    output logic [AW-1:0] sv_epc_o,
    output logic [1:0]    sv_emode_o,
    output logic [AW-1:0] flt_epc_o,
    output logic [1:0]    flt_emode_o
);
    import priv_pkg::*;

    logic   dbg_hit;
    logic   pend;
    logic   hwm_take;
    mode_e  mode_w, sv_emode_w, flt_emode_w;
    cause_e cause_w;

    priv_dbg_match #(.AW(AW)) u_match (
        .insn_valid (insn_valid),
        .insn_pc    (insn_pc),
        .dacc_valid (dacc_valid),
        .dacc_addr  (dacc_addr),
        .bkpt_en    (bkpt_en),
        .bkpt_addr  (bkpt_addr),
        .wpt_en     (wpt_en),
        .wpt_addr   (wpt_addr),
        .hit_o      (dbg_hit)
    );

    priv_async_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (hwm_evt),
        .clr_i  (hwm_take),
        .pend_o (pend)
    );

    priv_mode_fsm #(.AW(AW), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_valid    (insn_valid),
        .insn_pc       (insn_pc),
        .svc_req       (svc_req),
        .undef_req     (undef_req),
        .dbg_hit       (dbg_hit),
        .ret_req       (ret_req),
        .pend_i        (pend),
        .hwm_take_o    (hwm_take),
        .mode_o        (mode_w),
        .halted_o      (halted_o),
        .redir_valid_o (redir_valid_o),
        .redir_pc_o    (redir_pc_o),
        .cause_o       (cause_w),
        .sv_epc_o      (sv_epc_o),
        .sv_emode_o    (sv_emode_w),
        .flt_epc_o     (flt_epc_o),
        .flt_emode_o   (flt_emode_w)
    );

    assign mode_o      = mode_w;
    assign cause_o     = cause_w;
    assign sv_emode_o  = sv_emode_w;
    assign flt_emode_o = flt_emode_w;
endmodule

// File: tb/priv_exc_ctrl_bench.sv
`timescale 1ns/1ps
module priv_exc_ctrl_bench;
    localparam int AW = 24;
    localparam logic [31:0] VB = 32'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          insn_valid = 0, svc_req = 0, undef_req = 0, dacc_valid = 0;
    logic          bkpt_en = 0, wpt_en = 0, hwm_evt = 0, ret_req = 0;
    logic [AW-1:0] insn_pc = '0, dacc_addr = '0, bkpt_addr = '0, wpt_addr = '0;
    logic [1:0]    mode_o, sv_emode_o, flt_emode_o;
    logic          halted_o, redir_valid_o;
    logic [AW-1:0] redir_pc_o, sv_epc_o, flt_epc_o;
    logic [2:0]    cause_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    priv_exc_ctrl u_priv_exc_ctrl (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_pc(insn_pc),
        .svc_req(svc_req), .undef_req(undef_req), .dacc_valid(dacc_valid),
        .dacc_addr(dacc_addr), .bkpt_en(bkpt_en), .bkpt_addr(bkpt_addr),
        .wpt_en(wpt_en), .wpt_addr(wpt_addr), .hwm_evt(hwm_evt), .ret_req(ret_req),
        .mode_o(mode_o), .halted_o(halted_o), .redir_valid_o(redir_valid_o),
        .redir_pc_o(redir_pc_o), .cause_o(cause_o), .sv_epc_o(sv_epc_o),
        .sv_emode_o(sv_emode_o), .flt_epc_o(flt_epc_o), .flt_emode_o(flt_emode_o)
    );

    function automatic logic [31:0] vec(input int c);
        return VB + 32'(c) * 32'd16;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic cyc(input logic v, input logic [AW-1:0] pc, input logic s,
                       input logic u, input logic r, input logic h,
                       input logic dv, input logic [AW-1:0] da);
        @(negedge clk);
        insn_valid = v; insn_pc = pc; svc_req = s; undef_req = u;
        ret_req = r; hwm_evt = h; dacc_valid = dv; dacc_addr = da;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        insn_valid = 0; svc_req = 0; undef_req = 0; ret_req = 0; hwm_evt = 0;
        dacc_valid = 0; bkpt_en = 0; wpt_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "mode", 32'(mode_o), 0);
        chk("R1", "halted", 32'(halted_o), 0);
        chk("R1", "redir", 32'(redir_valid_o), 0);
        chk("R1", "sv_epc", 32'(sv_epc_o), 0);
        chk("R1", "flt_epc", 32'(flt_epc_o), 0);
        chk("R1", "flt_emode", 32'(flt_emode_o), 0);
        // R1: nothing pending, so a plain user boundary takes nothing
        cyc(1, 24'h40, 0, 0, 0, 0, 0, '0);
        chk("R1", "no pending take", 32'(redir_valid_o), 0);
    endtask

    task automatic t_svc_and_return();
        cyc(1, 24'h1000, 1, 0, 0, 0, 0, '0);
        chk("R2", "mode", 32'(mode_o), 1);
        chk("R2", "redir", 32'(redir_valid_o), 1);
        chk("R2", "vector", 32'(redir_pc_o), vec(0));
        chk("R2", "cause", 32'(cause_o), 0);
        chk("R2", "sv_epc", 32'(sv_epc_o), 32'h1000);
        chk("R2", "sv_emode", 32'(sv_emode_o), 0);
        idle();
        chk("R2", "strobe one cycle", 32'(redir_valid_o), 0);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R7", "mode after return", 32'(mode_o), 0);
        chk("R7", "return redir", 32'(redir_valid_o), 1);
        chk("R7", "return pc", 32'(redir_pc_o), 32'h1000);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R7", "user return ignored redir", 32'(redir_valid_o), 0);
        chk("R7", "user return ignored mode", 32'(mode_o), 0);
    endtask

    task automatic t_priority();
        bkpt_en = 1; bkpt_addr = 24'h2000;
        cyc(1, 24'h2000, 1, 1, 0, 0, 0, '0);
        chk("R3", "debug first cause", 32'(cause_o), 1);
        chk("R3", "debug vector", 32'(redir_pc_o), vec(1));
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        cyc(1, 24'h2100, 1, 1, 0, 0, 0, '0);
        chk("R3", "undef over svc", 32'(cause_o), 3);
        chk("R3", "undef vector", 32'(redir_pc_o), vec(3));
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        bkpt_en = 0;
    endtask

    task automatic t_comparators();
        wpt_en = 1; wpt_addr = 24'h5550;
        cyc(1, 24'h3000, 0, 0, 0, 0, 1, 24'h5550);
        chk("R4", "watchpoint hit", 32'(cause_o), 1);
        chk("R4", "watchpoint mode", 32'(mode_o), 1);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        cyc(1, 24'h3004, 0, 0, 0, 0, 0, 24'h5550);
        chk("R4", "no data access no hit", 32'(redir_valid_o), 0);
        cyc(0, '0, 0, 0, 0, 0, 1, 24'h5550);
        chk("R4", "no boundary no hit", 32'(redir_valid_o), 0);
        wpt_en = 0;
        cyc(1, 24'h3008, 0, 0, 0, 0, 1, 24'h5550);
        chk("R4", "disabled watchpoint", 32'(redir_valid_o), 0);
        bkpt_en = 0; bkpt_addr = 24'h300c;
        cyc(1, 24'h300c, 0, 0, 0, 0, 0, '0);
        chk("R4", "disabled breakpoint", 32'(redir_valid_o), 0);
        chk("R4", "still user", 32'(mode_o), 0);
    endtask

    task automatic t_double_fault();
        cyc(1, 24'h4000, 1, 0, 0, 0, 0, '0);
        cyc(1, 24'h0120, 0, 1, 0, 0, 0, '0);
        chk("R5", "fault mode", 32'(mode_o), 2);
        chk("R5", "cause", 32'(cause_o), 3);
        chk("R5", "vector", 32'(redir_pc_o), vec(3));
        chk("R5", "flt_epc", 32'(flt_epc_o), 32'h120);
        chk("R5", "flt_emode", 32'(flt_emode_o), 1);
        chk("R5", "sv_epc kept", 32'(sv_epc_o), 32'h4000);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R6", "fault return mode", 32'(mode_o), 1);
        chk("R6", "fault return pc", 32'(redir_pc_o), 32'h120);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R7", "back to user", 32'(mode_o), 0);
        chk("R7", "user pc", 32'(redir_pc_o), 32'h4000);
    endtask

    task automatic t_super_debug();
        cyc(1, 24'h4400, 1, 0, 0, 0, 0, '0);
        bkpt_en = 1; bkpt_addr = 24'h0104;
        cyc(1, 24'h0104, 0, 0, 0, 0, 0, '0);
        chk("R6", "sdbg mode", 32'(mode_o), 2);
        chk("R6", "sdbg cause", 32'(cause_o), 2);
        chk("R6", "sdbg vector", 32'(redir_pc_o), vec(2));
        bkpt_en = 0;
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R6", "resume supervisor", 32'(mode_o), 1);
        chk("R6", "resume pc", 32'(redir_pc_o), 32'h104);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
    endtask

    task automatic t_async();
        cyc(0, '0, 0, 0, 0, 1, 0, '0);
        chk("R8", "not taken off boundary", 32'(redir_valid_o), 0);
        idle();
        chk("R8", "held while no boundary", 32'(mode_o), 0);
        cyc(1, 24'h6000, 0, 0, 0, 0, 0, '0);
        chk("R8", "taken mode", 32'(mode_o), 1);
        chk("R8", "taken cause", 32'(cause_o), 4);
        chk("R8", "taken vector", 32'(redir_pc_o), vec(4));
        chk("R8", "saved pc", 32'(sv_epc_o), 32'h6000);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        cyc(1, 24'h6100, 0, 0, 0, 0, 0, '0);
        chk("R8", "cleared after take", 32'(redir_valid_o), 0);
        // same-cycle sync and async
        cyc(1, 24'h6200, 1, 0, 0, 1, 0, '0);
        chk("R8", "sync first", 32'(cause_o), 0);
        cyc(1, 24'h0130, 0, 0, 0, 0, 0, '0);
        chk("R8", "not taken in supervisor", 32'(redir_valid_o), 0);
        chk("R8", "stays supervisor", 32'(mode_o), 1);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        cyc(1, 24'h6300, 0, 0, 0, 0, 0, '0);
        chk("R8", "taken after return", 32'(cause_o), 4);
        chk("R8", "taken after return pc", 32'(sv_epc_o), 32'h6300);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
    endtask

    task automatic t_exc_beats_ret();
        cyc(1, 24'h7000, 1, 0, 0, 0, 0, '0);
        cyc(1, 24'h0140, 1, 0, 1, 0, 0, '0);
        chk("R10", "exception wins", 32'(mode_o), 2);
        chk("R10", "vector", 32'(redir_pc_o), vec(0));
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R10", "unwound", 32'(mode_o), 0);
    endtask

    task automatic t_halt();
        cyc(1, 24'h8000, 1, 0, 0, 0, 0, '0);
        cyc(1, 24'h0150, 1, 0, 0, 0, 0, '0);
        cyc(1, 24'h0160, 0, 1, 0, 0, 0, '0);
        chk("R9", "halted", 32'(halted_o), 1);
        chk("R9", "mode fault", 32'(mode_o), 2);
        chk("R9", "no redirect", 32'(redir_valid_o), 0);
        cyc(0, '0, 0, 0, 1, 0, 0, '0);
        chk("R9", "return ignored", 32'(halted_o), 1);
        chk("R9", "return no redirect", 32'(redir_valid_o), 0);
        do_reset();
        chk("R9", "reset leaves halt", 32'(halted_o), 0);
        chk("R9", "reset mode", 32'(mode_o), 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_svc_and_return();
        t_priority();
        t_comparators();
        t_double_fault();
        t_super_debug();
        t_async();
        t_exc_beats_ret();
        t_halt();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule